// File: doc/BRIEF.md
# Monochrome Pattern Generator

This block supplies a 2D drawing engine with one pattern bit and one pattern colour for each destination pixel. It stores a 64-bit monochrome pattern as two 32-bit words, two 32-bit colours, and a shape selector. The shape selector decides how the 64 bits are laid over the screen. The choices are an 8x8 tile, a horizontal strip 64 pixels wide and one pixel high, or a vertical strip one pixel wide and 64 pixels high. Software loads these five values through a 32-bit register-write port. A complete setup takes five writes.

The engine presents the current destination coordinate on `x_i`/`y_i`. The block wraps the coordinate into the pattern according to the shape and picks one pattern bit. It returns that bit together with the colour register the bit selects. The path from coordinate to output is purely combinational, so a new pixel can be evaluated every cycle. A solid fill is made by loading all ones into both mono words, which forces every pixel to select colour 1.

Top module: `mono_pattern_gen`

## Requirements
- R1: After reset, the shape is 8x8 (code 0), and all four data registers are zero. Every pixel therefore gives `pat_bit_o` = 0 and `pat_color_o` = 0.
- R2: While `wr_en_i` is high at a rising clock edge, `wr_data_i` is loaded into the register at `wr_addr_i`. The addresses are 0 = shape (bits [1:0] only), 1 = colour for bit 0, 2 = colour for bit 1, 3 = mono word 1, and 4 = mono word 2. The new value affects the outputs right after that edge.
- R3: Shape code 0 (8x8) uses pattern bit index {y[2:0], x[2:0]}, with y in the upper three bits.
- R4: Shape code 1 (64x1) uses pattern bit index x[5:0].
- R5: Shape code 2 (1x64) uses pattern bit index y[5:0].
- R6: Shape code 3 selects exactly as shape code 0 does.
- R7: Indices 0 to 31 are bits 0 to 31 of mono word 1, with index 0 at its LSB. Indices 32 to 63 are bits 0 to 31 of mono word 2.
- R8: `pat_color_o` equals the colour for bit 1 when `pat_bit_o` is 1, and the colour for bit 0 otherwise.
- R9: With both mono words all ones, every coordinate under every shape gives `pat_bit_o` = 1.
- R10: A write cycle with `wr_en_i` low, or with an address from 5 to 7, leaves every register unchanged.
- R11: Coordinate bits above those used by the selected shape do not affect the outputs. The outputs follow `x_i`/`y_i` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| x_i | input | 16 | Destination pixel x coordinate |
| y_i | input | 16 | Destination pixel y coordinate |
| pat_bit_o | output | 1 | Selected pattern bit |
| pat_color_o | output | 32 | Colour selected by the pattern bit |

## Verification
The assertions assume two things. First, the write strobe and the address are known whenever reset is released. Second, a register write and a coordinate check never fall in the same cycle, so the pattern state is stable while a pixel is being evaluated. The stimulus respects both by keeping reset asserted with the strobe low. It performs writes only in cycles that have no queued expectation, and it changes the coordinate only on the falling edge. The coordinates sweep all 64 indices for each shape. Upper coordinate bits are set deliberately to show that they are ignored.

// File: rtl/pat_pkg.sv
package pat_pkg;
  typedef enum logic [1:0] {
    SHP_TILE8 = 2'd0,
    SHP_ROW64 = 2'd1,
    SHP_COL64 = 2'd2,
    SHP_RSVD  = 2'd3
  } shape_e;

  localparam int unsigned REG_ADDR_W = 3;
  localparam int unsigned NUM_WORDS  = 4;   // col0, col1, mono lo, mono hi
  localparam int unsigned PAT_BITS   = 64;
  localparam int unsigned IDX_W      = $clog2(PAT_BITS);
  localparam int unsigned TILE_W     = 3;   // log2 of 8x8 tile edge

  localparam logic [REG_ADDR_W-1:0] A_SHAPE   = 3'd0;
  localparam logic [REG_ADDR_W-1:0] A_COL0    = 3'd1;
  localparam logic [REG_ADDR_W-1:0] A_COL1    = 3'd2;
  localparam logic [REG_ADDR_W-1:0] A_MONO_LO = 3'd3;
  localparam logic [REG_ADDR_W-1:0] A_MONO_HI = 3'd4;

  localparam int unsigned W_COL0    = 0;
  localparam int unsigned W_COL1    = 1;
  localparam int unsigned W_MONO_LO = 2;
  localparam int unsigned W_MONO_HI = 3;
endpackage

// File: rtl/pat_regs.sv
module pat_regs
  import pat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output shape_e                shape_o,
  output logic [DATA_W-1:0]     col0_o,
  output logic [DATA_W-1:0]     col1_o,
  output logic [DATA_W-1:0]     mono_lo_o,
  output logic [DATA_W-1:0]     mono_hi_o
);
  shape_e            shape_q;
  logic [DATA_W-1:0] word_q [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shape_q <= SHP_TILE8;
    else if (wr_en_i && wr_addr_i == A_SHAPE) shape_q <= shape_e'(wr_data_i[1:0]);
  end

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    localparam logic [REG_ADDR_W-1:0] ADDR = REG_ADDR_W'(k + 1);
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  word_q[k] <= '0;
      else if (hit) word_q[k] <= wr_data_i;
    end

    // R10
    word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_addr_i == ADDR) |=> $stable(word_q[k]));
    // R2
    word_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == ADDR) |=> word_q[k] == $past(wr_data_i));
  end

  assign shape_o   = shape_q;
  assign col0_o    = word_q[W_COL0];
  assign col1_o    = word_q[W_COL1];
  assign mono_lo_o = word_q[W_MONO_LO];
  assign mono_hi_o = word_q[W_MONO_HI];

  // R2
  shape_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_SHAPE) |=> shape_q == $past(wr_data_i[1:0]));
  // R10
  shape_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == A_SHAPE) |=> $stable(shape_q));
endmodule

// File: rtl/pat_index.sv
module pat_index
  import pat_pkg::*;
#(
  parameter int unsigned COORD_W = 16
) (
  input  shape_e             shape_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    unique case (shape_i)
      SHP_ROW64: idx_o = x_i[IDX_W-1:0];
      SHP_COL64: idx_o = y_i[IDX_W-1:0];
      default:   idx_o = {y_i[TILE_W-1:0], x_i[TILE_W-1:0]};  // tile and reserved code
    endcase
  end
endmodule

// File: rtl/pat_color_sel.sv
module pat_color_sel
  import pat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] mono_lo_i,
  input  logic [DATA_W-1:0] mono_hi_i,
  input  logic [DATA_W-1:0] col0_i,
  input  logic [DATA_W-1:0] col1_i,
  output logic              bit_o,
  output logic [DATA_W-1:0] color_o
);
  localparam int unsigned PW = 2 * DATA_W;
  logic [PW-1:0] pat;

  assign pat     = {mono_hi_i, mono_lo_i};
  assign bit_o   = pat[idx_i];
  assign color_o = bit_o ? col1_i : col0_i;
endmodule

// File: rtl/mono_pattern_gen.sv
module mono_pattern_gen
  import pat_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned COORD_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [COORD_W-1:0]    x_i,
  input  logic [COORD_W-1:0]    y_i,
  output logic                  pat_bit_o,
  output logic [DATA_W-1:0]     pat_color_o
);
  shape_e            shape;
  logic [DATA_W-1:0] col0, col1, mono_lo, mono_hi;
  logic [IDX_W-1:0]  idx;

  pat_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .shape_o   (shape),
    .col0_o    (col0),
    .col1_o    (col1),
    .mono_lo_o (mono_lo),
    .mono_hi_o (mono_hi)
  );

  pat_index #(.COORD_W(COORD_W)) u_index (
    .shape_i (shape),
    .x_i     (x_i),
    .y_i     (y_i),
    .idx_o   (idx)
  );

  pat_color_sel #(.DATA_W(DATA_W)) u_sel (
    .idx_i     (idx),
    .mono_lo_i (mono_lo),
    .mono_hi_i (mono_hi),
    .col0_i    (col0),
    .col1_i    (col1),
    .bit_o     (pat_bit_o),
    .color_o   (pat_color_o)
  );

  // R9
  solid_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mono_lo && &mono_hi) |-> pat_bit_o && pat_color_o == col1);
  // R6
  rsvd_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shape == SHP_RSVD) |-> idx == {y_i[TILE_W-1:0], x_i[TILE_W-1:0]});
  // R8
  same_color_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col0 == col1) |-> pat_color_o == col0);
  // R7
  lsb_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx == '0) |-> pat_bit_o == mono_lo[0]);
endmodule

// File: tb/mono_pattern_gen_tb.sv
module mono_pattern_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] x = '0, y = '0;
  logic        pat_bit;
  logic [31:0] pat_color;

  always #2 clk = ~clk;  // 250 MHz

  mono_pattern_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .x_i(x), .y_i(y),
    .pat_bit_o(pat_bit), .pat_color_o(pat_color)
  );

  typedef struct {
    logic        b;
    logic [31:0] c;
    string       tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model of register state
  int          m_shape = 0;
  logic [31:0] m_c0 = '0, m_c1 = '0, m_lo = '0, m_hi = '0;

  function automatic logic model_bit(logic [15:0] px, logic [15:0] py);
    logic [63:0] p;
    int idx;
    p = {m_hi, m_lo};
    case (m_shape)
      1: idx = int'(px[5:0]);
      2: idx = int'(py[5:0]);
      default: idx = int'(py[2:0]) * 8 + int'(px[2:0]);
    endcase
    return p[idx];
  endfunction

  task automatic reg_write(logic en, logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (en) begin
      case (a)
        3'd0: m_shape = int'(d[1:0]);
        3'd1: m_c0 = d;
        3'd2: m_c1 = d;
        3'd3: m_lo = d;
        3'd4: m_hi = d;
        default: ;
      endcase
    end
  endtask

  task automatic apply(logic [15:0] px, logic [15:0] py, string tag);
    exp_t e;
    @(negedge clk);
    x = px; y = py;
    e.b = model_bit(px, py);
    e.c = e.b ? m_c1 : m_c0;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (pat_bit !== e.b || pat_color !== e.c) begin
          fails++;
          $display("FAIL %s x=%0h y=%0h bit=%0b/%0b color=%08h/%08h (actual/expected)",
                   e.tag, x, y, pat_bit, e.b, pat_color, e.c);
        end
      end
    end
  end

  task automatic sweep(string tag);
    for (int i = 0; i < 64; i++) begin
      logic [15:0] px, py;
      px = 16'(i * 7 + 3) | 16'h4000;
      py = 16'(i * 5 + 1) | 16'h0840;
      case (m_shape)
        1: px = 16'(i) | 16'(i * 1024);
        2: py = 16'(i) | 16'(i * 512);
        default: begin px = 16'(i % 8) | 16'hA0C8; py = 16'(i / 8) | 16'h5538; end
      endcase
      apply(px, py, tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    apply(16'h0000, 16'h0000, "R1");
    apply(16'h1234, 16'h00FF, "R1");
    apply(16'hFFFF, 16'hFFFF, "R1");
    drain();
    // R2 register loads
    reg_write(1, 3'd1, 32'hA5A5_0001);
    reg_write(1, 3'd2, 32'h5A5A_FFFE);
    reg_write(1, 3'd3, 32'h1234_5678);
    reg_write(1, 3'd4, 32'h9ABC_DEF1);
    reg_write(1, 3'd0, 32'hFFFF_FFF0);  // only bits [1:0] kept -> shape 0
    apply(16'd0, 16'd0, "R2");
    apply(16'd7, 16'd7, "R2");
    // R3 / R7 / R8 / R11 8x8 tile
    sweep("R3");
    // R4 64x1
    reg_write(1, 3'd0, 32'd1);
    sweep("R4");
    apply(16'hFFDF, 16'h1234, "R7");  // idx 31
    apply(16'h0020, 16'h0000, "R7");  // idx 32
    // R5 1x64
    reg_write(1, 3'd0, 32'd2);
    sweep("R5");
    // R6 reserved code
    reg_write(1, 3'd0, 32'd3);
    sweep("R6");
    // R10 ignored writes
    reg_write(1, 3'd5, 32'hFFFF_FFFF);
    reg_write(1, 3'd6, 32'h0000_0000);
    reg_write(1, 3'd7, 32'h0000_0001);
    reg_write(0, 3'd3, 32'h0000_0000);
    reg_write(0, 3'd0, 32'h0000_0001);
    sweep("R10");
    // R8 swap colours, mono changed
    reg_write(1, 3'd1, 32'h0F0F_0F0F);
    reg_write(1, 3'd2, 32'hF0F0_F0F0);
    reg_write(1, 3'd3, 32'h8000_0001);
    reg_write(1, 3'd4, 32'h7FFF_FFFE);
    reg_write(1, 3'd0, 32'd0);
    sweep("R8");
    // R9 solid pattern, five-write setup
    reg_write(1, 3'd0, 32'd0);
    reg_write(1, 3'd1, 32'hFFFF_FFFF);
    reg_write(1, 3'd2, 32'hFFFF_FFFF);
    reg_write(1, 3'd3, 32'hFFFF_FFFF);
    reg_write(1, 3'd4, 32'hFFFF_FFFF);
    for (int s = 0; s < 4; s++) begin
      reg_write(1, 3'd0, 32'(s));
      apply(16'h0000, 16'h0000, "R9");
      apply(16'h0123, 16'hBEEF, "R9");
      apply(16'hFFFF, 16'h003F, "R9");
    end
    drain();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule